// File: doc/BRIEF.md
# Directory Home Controller for Cache Coherence

This block is the home-node directory of a distributed shared-memory machine. It owns a small set of memory blocks. For every block it keeps a coherence state and a vector with one presence bit per processor. The state is one of three: not cached anywhere, held read-only by one or more caches, or held writable by exactly one cache.

Requesting caches send it three kinds of request: read miss, write miss, and write-back of a dirty block. The controller answers each one with explicit point-to-point messages on a valid/ready output port. The kinds of message are a data reply to the requester, an invalidate to each sharer, a fetch to the current owner, and a fetch-with-invalidate to the current owner.

When the owner has to supply the current copy, the controller stops and waits on a separate return port for that data. It writes the data into memory and then forwards it to the requester.

The controller serves one request at a time. While a request is in flight it refuses new ones. Messages are assumed to arrive in the order in which they were sent.

Top module: `dir_home`

## Requirements
- R1: After reset every block is not cached (state U) with an empty presence vector, and every memory word is zero; `req_ready` is high and `msg_valid` is low.
- R2: A read miss (`req_kind` 0) to a block in state U produces one data reply (`msg_kind` 0) to the requester, carrying the memory word. The block becomes read-shared (state S) with only the requester present.
- R3: A read miss to a block in state S produces a data reply with the memory word and adds the requester to the presence vector.
- R4: A write miss (`req_kind` 1) to a block in state U produces a data reply with the memory word. The block becomes writable (state E), owned by the requester alone.
- R5: A write miss to a block in state S first sends one invalidate (`msg_kind` 1) to each present processor other than the requester, in ascending processor number, one per accepted message. It then sends the data reply, and the block becomes state E owned by the requester.
- R6: A read miss to a block in state E sends a fetch (`msg_kind` 2) to the owner and then waits for `fill_valid`. The returned word is written to memory and replied to the requester. The block becomes state S with the old owner and the requester present.
- R7: A write miss to a block in state E sends a fetch-invalidate (`msg_kind` 3) to the owner. The returned word is written to memory and replied to the requester, who becomes the sole owner in state E.
- R8: A write-back (`req_kind` 2) from the owner of a block in state E writes `req_data` to memory. The block returns to state U with an empty presence vector, and no message is sent.
- R9: A write-back from a processor that does not own the block, a write-back to a block that is not in state E, and `req_kind` 3 all leave the state and memory unchanged and send no message.
- R10: `req_ready` stays low from the acceptance of a read or write miss until its data reply is accepted, including the whole time spent waiting for owner data.
- R11: While `msg_valid` is high and `msg_ready` is low, the kind, destination, block and data of the message hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 no operation |
| req_src | input | PW | Requesting processor number |
| req_blk | input | BW | Block index |
| req_data | input | DW | Write-back data |
| fill_valid | input | 1 | Owner returns the fetched block |
| fill_data | input | DW | Fetched block contents |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network accepts the message |
| msg_kind | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-invalidate |
| msg_dst | output | PW | Destination processor |
| msg_blk | output | BW | Block index of the message |
| msg_data | output | DW | Reply data (zero for other kinds) |

## Verification
The bench targets the following corner cases and the failure each one would expose:

- **Upgrade from a block shared by every processor.** The requester must not receive an invalidate, and the others must be invalidated in ascending order. A controller that invalidated the requester, or that walked the presence vector in the wrong order, would emit an extra or misordered invalidate.
- **Owner data overtaking memory.** After a fetch, the reply must carry the owner's value rather than the stale memory word, and a later read from state S must see that value. A controller that skipped the memory update would return old data one request later.
- **Stray write-backs.** A write-back from a non-owner must not move the block to state U. If it did, the next read would be answered from memory instead of triggering a fetch.
- **Ordering under back-pressure.** A long randomised run with back-pressure on the output port checks that no message changes while it is stalled and that no request is taken while owner data is outstanding.

// File: rtl/dir_home.sv
module dir_home #(
  parameter int NPROC = 4,
  parameter int NBLK  = 16,
  parameter int DW    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_kind,
  input  logic [((NPROC>1)?$clog2(NPROC):1)-1:0] req_src,
  input  logic [((NBLK>1)?$clog2(NBLK):1)-1:0]   req_blk,
  input  logic [DW-1:0]        req_data,
  input  logic                 fill_valid,
  input  logic [DW-1:0]        fill_data,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [1:0]           msg_kind,
  output logic [((NPROC>1)?$clog2(NPROC):1)-1:0] msg_dst,
  output logic [((NBLK>1)?$clog2(NBLK):1)-1:0]   msg_blk,
  output logic [DW-1:0]        msg_data
);
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1;
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1;

  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2;
  localparam logic [1:0] M_DATA = 2'd0, M_INV = 2'd1, M_FETCH = 2'd2, M_FINV = 2'd3;

  typedef enum logic [1:0] {D_UNC, D_SHR, D_EXC} dstate_t;
  typedef enum logic [2:0] {S_IDLE, S_INV, S_FETCH, S_WAIT, S_REPLY} phase_t;

  logic [DW-1:0]    mem_q [NBLK];
  dstate_t          dir_q [NBLK];
  logic [NPROC-1:0] shr_q [NBLK];

  phase_t           ph_q;
  logic [PW-1:0]    src_q, owner_q;
  logic [BW-1:0]    blk_q;
  logic             wr_q;
  logic [NPROC-1:0] pend_q;
  logic [DW-1:0]    data_q;

  function automatic logic [PW-1:0] first_one(input logic [NPROC-1:0] m);
    first_one = '0;
    for (int i = NPROC - 1; i >= 0; i--)
      if (m[i]) first_one = PW'(i);
  endfunction

  dstate_t          cur_st;
  logic [NPROC-1:0] cur_sh, req_bit, src_bit, inv_bit, pend_left, upg_pend;
  logic             acc, fire, wb_ok;

  assign cur_st    = dir_q[req_blk];
  assign cur_sh    = shr_q[req_blk];
  assign req_bit   = NPROC'(1) << req_src;
  assign src_bit   = NPROC'(1) << src_q;
  assign upg_pend  = (cur_st == D_SHR) ? (cur_sh & ~req_bit) : '0;
  assign wb_ok     = (cur_st == D_EXC) && (cur_sh == req_bit);

  assign req_ready = (ph_q == S_IDLE);
  assign acc       = req_valid && req_ready;
  assign msg_valid = (ph_q == S_INV) || (ph_q == S_FETCH) || (ph_q == S_REPLY);
  assign fire      = msg_valid && msg_ready;

  assign msg_kind  = (ph_q == S_INV)   ? M_INV :
                     (ph_q == S_FETCH) ? (wr_q ? M_FINV : M_FETCH) : M_DATA;
  assign msg_dst   = (ph_q == S_INV)   ? first_one(pend_q) :
                     (ph_q == S_FETCH) ? owner_q : src_q;
  assign msg_blk   = blk_q;
  assign msg_data  = (ph_q == S_REPLY) ? data_q : '0;

  assign inv_bit   = NPROC'(1) << msg_dst;
  assign pend_left = pend_q & ~inv_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= S_IDLE;
      src_q   <= '0;
      owner_q <= '0;
      blk_q   <= '0;
      wr_q    <= 1'b0;
      pend_q  <= '0;
      data_q  <= '0;
      for (int i = 0; i < NBLK; i++) begin
        mem_q[i] <= '0;
        dir_q[i] <= D_UNC;
        shr_q[i] <= '0;
      end
    end else begin
      case (ph_q)
        S_IDLE: if (acc) begin
          src_q <= req_src;
          blk_q <= req_blk;
          wr_q  <= (req_kind == K_WR);
          case (req_kind)
            K_RD: begin
              if (cur_st == D_EXC) begin
                owner_q <= first_one(cur_sh);
                ph_q    <= S_FETCH;
              end else begin
                data_q         <= mem_q[req_blk];
                dir_q[req_blk] <= D_SHR;
                shr_q[req_blk] <= (cur_st == D_UNC) ? req_bit : (cur_sh | req_bit);
                ph_q           <= S_REPLY;
              end
            end
            K_WR: begin
              if (cur_st == D_EXC) begin
                owner_q <= first_one(cur_sh);
                ph_q    <= S_FETCH;
              end else begin
                pend_q         <= upg_pend;
                data_q         <= mem_q[req_blk];
                dir_q[req_blk] <= D_EXC;
                shr_q[req_blk] <= req_bit;
                ph_q           <= (upg_pend != '0) ? S_INV : S_REPLY;
              end
            end
            K_WB: begin
              if (wb_ok) begin
                mem_q[req_blk] <= req_data;
                dir_q[req_blk] <= D_UNC;
                shr_q[req_blk] <= '0;
              end
            end
            default: ;
          endcase
        end
        S_INV: if (fire) begin
          pend_q <= pend_left;
          if (pend_left == '0) ph_q <= S_REPLY;
        end
        S_FETCH: if (fire) ph_q <= S_WAIT;
        S_WAIT: if (fill_valid) begin
          mem_q[blk_q] <= fill_data;
          data_q       <= fill_data;
          if (wr_q) begin
            shr_q[blk_q] <= src_bit;
          end else begin
            shr_q[blk_q] <= shr_q[blk_q] | src_bit;
            dir_q[blk_q] <= D_SHR;
          end
          ph_q <= S_REPLY;
        end
        S_REPLY: if (fire) ph_q <= S_IDLE;
        default: ph_q <= S_IDLE;
      endcase
    end
  end

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) && $stable(msg_dst)
                                && $stable(msg_blk) && $stable(msg_data)); // R11
  AST_INV_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready && msg_kind == M_INV
      |=> !(msg_valid && msg_kind == M_INV) || (msg_dst > $past(msg_dst))); // R5
  AST_INV_SKIPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == M_INV |-> msg_dst != src_q); // R5
  AST_READY_AFTER_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> $past(msg_valid && msg_ready && msg_kind == M_DATA)); // R10
  AST_EXC_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == S_REPLY && dir_q[blk_q] == D_EXC |-> $countones(shr_q[blk_q]) == 1); // R4
  AST_UNC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    dir_q[blk_q] == D_UNC |-> shr_q[blk_q] == '0); // R8
endmodule

// File: tb/dir_home_test.sv
`timescale 1ns/1ps
module dir_home_test;
  localparam int NP = 4, NB = 4, DW = 8;
  localparam int U = 0, S = 1, E = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, fill_valid = 0, msg_ready = 1;
  logic req_ready, msg_valid;
  logic [1:0] req_kind = 0, msg_kind;
  logic [1:0] req_src = 0, req_blk = 0, msg_dst, msg_blk;
  logic [DW-1:0] req_data = 0, fill_data = 0, msg_data;

  dir_home #(.NPROC(NP), .NBLK(NB), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
    .fill_valid(fill_valid), .fill_data(fill_data), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_kind(msg_kind), .msg_dst(msg_dst),
    .msg_blk(msg_blk), .msg_data(msg_data));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int m_st [NB];
  logic [NP-1:0] m_sh [NB];
  logic [DW-1:0] m_mem [NB], m_own [NB];
  logic [15:0] lfsr = 16'hACE1;
  bit bp_on = 0;

  task automatic step_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int owner_of(input logic [NP-1:0] m);
    for (int i = 0; i < NP; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic expect_msg(input int k, input int d, input int b, input int dat, input bit cd, input string tag);
    int guard = 0;
    bit done = 0;
    while (!done) begin
      step_rand();
      msg_ready = bp_on ? lfsr[0] : 1'b1;
      if (msg_valid && msg_ready) begin
        chk(msg_kind == 2'(k), tag, "msg kind", msg_kind, k);
        chk(msg_dst == 2'(d), tag, "msg destination", msg_dst, d);
        chk(msg_blk == 2'(b), tag, "msg block", msg_blk, b);
        if (cd) chk(msg_data == DW'(dat), tag, "msg data", msg_data, dat);
        done = 1;
      end
      @(posedge clk); @(negedge clk);
      guard++;
      if (!done && guard > 60) begin
        chk(0, tag, "message missing, kind", -1, k);
        done = 1;
      end
    end
    msg_ready = 1;
  endtask

  task automatic serve_fill(input logic [DW-1:0] v, input string tag);
    int n;
    chk(!req_ready, "R10", "req_ready while waiting", req_ready, 0);
    step_rand();
    n = lfsr % 3;
    repeat (n) begin
      @(posedge clk); @(negedge clk);
      chk(!req_ready && !msg_valid, tag, "quiet while waiting", {req_ready, msg_valid}, 0);
    end
    fill_valid = 1; fill_data = v;
    @(posedge clk); @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_req(input int k, input int src, input int b, input logic [DW-1:0] wd);
    logic [NP-1:0] bitm;
    int o;
    bitm = NP'(1) << src;
    o = owner_of(m_sh[b]);
    chk(req_ready, "R10", "ready before request", req_ready, 1);
    req_valid = 1; req_kind = 2'(k); req_src = 2'(src); req_blk = 2'(b); req_data = wd;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    if (k == 0) begin
      if (m_st[b] == E) begin
        expect_msg(2, o, b, 0, 0, "R6");
        serve_fill(m_own[b], "R6");
        m_mem[b] = m_own[b];
        expect_msg(0, src, b, m_mem[b], 1, "R6");
        m_sh[b] = m_sh[b] | bitm; m_st[b] = S;
      end else begin
        expect_msg(0, src, b, m_mem[b], 1, (m_st[b] == U) ? "R2" : "R3");
        m_sh[b] = (m_st[b] == U) ? bitm : (m_sh[b] | bitm); m_st[b] = S;
      end
    end else if (k == 1) begin
      if (m_st[b] == E) begin
        expect_msg(3, o, b, 0, 0, "R7");
        serve_fill(m_own[b], "R7");
        m_mem[b] = m_own[b];
        expect_msg(0, src, b, m_mem[b], 1, "R7");
      end else begin
        if (m_st[b] == S)
          for (int p = 0; p < NP; p++)
            if (m_sh[b][p] && p != src) expect_msg(1, p, b, 0, 0, "R5");
        expect_msg(0, src, b, m_mem[b], 1, (m_st[b] == U) ? "R4" : "R5");
      end
      m_st[b] = E; m_sh[b] = bitm; m_own[b] = wd;
    end else begin
      if (k == 2 && m_st[b] == E && m_sh[b] == bitm) begin
        m_mem[b] = wd; m_st[b] = U; m_sh[b] = '0;
        chk(!msg_valid, "R8", "no message on write-back", msg_valid, 0);
      end else begin
        chk(!msg_valid, "R9", "no message on ignored write-back", msg_valid, 0);
      end
    end
    chk(!msg_valid && req_ready, "R10", "idle after request", {msg_valid, req_ready}, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k, src, b;
    for (int i = 0; i < NB; i++) begin
      m_st[i] = U; m_sh[i] = '0; m_mem[i] = '0; m_own[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk(req_ready, "R1", "req_ready after reset", req_ready, 1);
    chk(!msg_valid, "R1", "msg_valid after reset", msg_valid, 0);
    for (int i = 0; i < NB; i++) begin
      do_req(0, i % NP, i, 0);
      chk(m_mem[i] == 0, "R1", "model memory zero", m_mem[i], 0);
    end

    do_req(1, 0, 0, 8'd10);
    do_req(0, 1, 0, 0);
    do_req(1, 1, 0, 8'd20);
    do_req(1, 2, 0, 8'd40);
    do_req(2, 1, 0, 8'd99);
    do_req(0, 3, 0, 0);
    do_req(2, 0, 1, 8'd77);
    do_req(2, 0, 0, 8'd55);
    do_req(3, 2, 0, 8'd66);
    do_req(1, 3, 0, 8'd12);
    do_req(2, 3, 0, 8'd13);
    do_req(0, 0, 0, 0);

    for (int p = 0; p < NP; p++) do_req(0, (p + 3) % NP, 2, 0);
    do_req(1, 1, 2, 8'd33);
    for (int p = 0; p < NP; p++) do_req(0, p, 3, 0);
    do_req(1, 0, 3, 8'd44);

    bp_on = 1;
    for (int it = 0; it < 600; it++) begin
      step_rand();
      k = lfsr[1:0]; src = lfsr[3:2]; b = lfsr[5:4];
      step_rand();
      if (k == 3 && lfsr[0]) k = 0;
      if (k < 2 && m_st[b] == E && owner_of(m_sh[b]) == src) src = (src + 1) % NP;
      if (k == 2 && m_st[b] == E && lfsr[1]) begin
        src = owner_of(m_sh[b]);
        do_req(2, src, b, m_own[b]);
      end else begin
        do_req(k, src, b, lfsr[15:8]);
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule